// File: doc/BRIEF.md
# Interpolated Angle to Quadrature Generator

This block turns an absolute angle position code, given in core interpolation steps, into a pair of square waves A and B that are 90 degrees apart and a direction flag. A counter inside the block wraps at the core step count. It walks toward each accepted position code at one core step per clock. The quadrature state comes from this counter after a power-of-two division, so nine output resolutions share three core resolutions of 64, 48 and 40 steps per cycle.

A hysteresis band of one core step sits between the two directions. A position code that stands still, or that dithers by one step against the current direction, never moves the outputs. A reversal is taken only when the code has gone at least two steps back. The counter then follows one step behind the code. A phase-select input swaps which output leads for a given direction.

Position codes arrive on a valid/ready stream. `pos_ready` is high when the counter has reached its last target. A code is taken on a clock edge only when `pos_valid` and `pos_ready` are both high. While the counter walks, `pos_ready` stays low. The producer must then hold or withdraw its code, and a code offered during that time is neither taken nor stored. The two resolution selects are sampled only while synchronous reset is asserted. The phase select acts at once.

Top module: `angle_quad_gen`

## Requirements
- R1: During and right after synchronous reset, `quad_a`=0, `quad_b`=0, `dir_up`=1 and `pos_ready`=1, and the internal position is 0.
- R2: Each select uses the 2-bit code 00=low, 01=open, 10=high, and 11 is read as open. The selects (hi,lo) give the interpolation factor IPF: high/high=16, high/open=12, high/low=10, open/high=8, open/open=5, open/low=4, low/high=3, low/open=2, low/low=1. The core step count N is 64 for 16, 8, 4, 2 and 1, 48 for 12 and 3, and 40 for 10 and 5. One full forward cycle of codes gives exactly 4×IPF edges on A and B combined.
- R3: A change on the resolution selects has no effect until the next synchronous reset.
- R4: The quadrature index q is (position / DIV) mod 4, where DIV = N / (4×IPF). With `phase_sel` low (00), open (01) or 11, q=0,1,2,3 maps to (A,B)=00,01,11,10, so B leads A as the position increases.
- R5: With `phase_sel` high (10), q=0,1,2,3 maps to (A,B)=00,10,11,01, so A leads B as the position increases. The select acts without a reset.
- R6: While moving up, a code one step below the position is ignored: no output edge and `dir_up` stays high. The same holds mirrored while moving down. Dithering by one step produces no edges.
- R7: A code k≥2 steps against the current direction flips `dir_up` and moves the position k−1 steps.
- R8: After a code is accepted, the position moves one core step per clock and `pos_ready` is low for exactly as many cycles as steps are taken. Codes offered while `pos_ready` is low are ignored.
- R9: The position wraps modulo N. Each code is reached by the shorter way round, with the signed distance taken in [−N/2, N/2).
- R10: A and B never change in the same cycle while `phase_sel` is steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; also loads the resolution selects |
| pos_valid | input | 1 | Position code offered |
| pos_ready | output | 1 | Block can take a position code |
| pos_code | input | POS_W | Absolute position in core steps (0..N−1); a value at or above N is folded once |
| res_sel_hi | input | 2 | First resolution select (00 low, 01 open, 10 high, 11 open) |
| res_sel_lo | input | 2 | Second resolution select, same coding |
| phase_sel | input | 2 | Phase select; 10 makes A lead on upward motion |
| quad_a | output | 1 | Incremental output A |
| quad_b | output | 1 | Incremental output B |
| dir_up | output | 1 | 1 while the last taken motion was upward |

## Verification
Two things can happen in the same step: a reversal decision and a wrap of the position through zero. The bench provokes this by parking the position at N−1 while moving down. It then offers a code a few steps past zero. The distance must fold across the wrap, the reversal must cost one hysteresis step, and the walk must then cross the 0/N−1 boundary. The result is judged at the ports by the number of A/B edges, the final (A,B) pair and `dir_up`, for both the 64-step and the 48-step core.

// File: rtl/aqg_pkg.sv
package aqg_pkg;

  typedef logic [1:0] tri_sel_t;
  localparam tri_sel_t TRI_LO   = 2'b00;
  localparam tri_sel_t TRI_OPEN = 2'b01;
  localparam tri_sel_t TRI_HI   = 2'b10;

  typedef enum logic [1:0] {
    CORE_64 = 2'd0,
    CORE_48 = 2'd1,
    CORE_40 = 2'd2
  } core_res_e;

  typedef struct packed {
    core_res_e  core;
    logic [2:0] div_log2;
  } res_cfg_t;

  function automatic tri_sel_t tri_norm(input tri_sel_t s);
    return (s == 2'b11) ? TRI_OPEN : s;
  endfunction

  function automatic res_cfg_t res_decode(input tri_sel_t sh, input tri_sel_t sl);
    res_cfg_t c;
    tri_sel_t h;
    tri_sel_t l;
    h = tri_norm(sh);
    l = tri_norm(sl);
    c.core     = CORE_64;
    c.div_log2 = 3'd0;
    case ({h, l})
      {TRI_HI,   TRI_HI}:   begin c.core = CORE_64; c.div_log2 = 3'd0; end
      {TRI_HI,   TRI_OPEN}: begin c.core = CORE_48; c.div_log2 = 3'd0; end
      {TRI_HI,   TRI_LO}:   begin c.core = CORE_40; c.div_log2 = 3'd0; end
      {TRI_OPEN, TRI_HI}:   begin c.core = CORE_64; c.div_log2 = 3'd1; end
      {TRI_OPEN, TRI_OPEN}: begin c.core = CORE_40; c.div_log2 = 3'd1; end
      {TRI_OPEN, TRI_LO}:   begin c.core = CORE_64; c.div_log2 = 3'd2; end
      {TRI_LO,   TRI_HI}:   begin c.core = CORE_48; c.div_log2 = 3'd2; end
      {TRI_LO,   TRI_OPEN}: begin c.core = CORE_64; c.div_log2 = 3'd3; end
      default:              begin c.core = CORE_64; c.div_log2 = 3'd4; end
    endcase
    return c;
  endfunction

endpackage

// File: rtl/aqg_res_cfg.sv
module aqg_res_cfg
  import aqg_pkg::*;
#(
  parameter int POS_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       sel_hi,
  input  logic [1:0]       sel_lo,
  output logic [POS_W:0]   step_cnt,
  output logic [2:0]       div_log2
);
  localparam int CW = POS_W + 1;

  res_cfg_t cfg_q;

  always_ff @(posedge clk) begin
    if (rst) cfg_q <= res_decode(sel_hi, sel_lo);
  end

  always_comb begin
    case (cfg_q.core)
      CORE_48: step_cnt = CW'(48);
      CORE_40: step_cnt = CW'(40);
      default: step_cnt = CW'(64);
    endcase
    div_log2 = cfg_q.div_log2;
  end

  // R3: the configuration only moves under reset
  a_r3_cfg_hold: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ($stable(step_cnt) && $stable(div_log2)));

endmodule

// File: rtl/aqg_tracker.sv
module aqg_tracker #(
  parameter int POS_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [POS_W-1:0] in_code,
  input  logic [POS_W:0]   step_cnt,
  output logic [POS_W-1:0] pos_o,
  output logic             dir_up_o
);
  localparam int CW = POS_W + 1;
  localparam int DW = POS_W + 3;
  localparam logic signed [DW-1:0] S_ZERO = '0;
  localparam logic signed [DW-1:0] S_ONE  = DW'(1);
  localparam logic signed [DW-1:0] S_MONE = -S_ONE;

  logic [POS_W-1:0] pos_q;
  logic [POS_W-1:0] rem_q;
  logic             dir_q;

  logic [CW-1:0]          code_x;
  logic [CW-1:0]          code_f;
  logic [CW-1:0]          last_w;
  logic [POS_W-1:0]       pos_last;
  logic signed [DW-1:0]   cnt_s;
  logic signed [DW-1:0]   half_s;
  logic signed [DW-1:0]   diff_raw;
  logic signed [DW-1:0]   diff;
  logic [POS_W-1:0]       steps;
  logic                   dir_nx;
  logic [POS_W-1:0]       pos_step;

  assign in_ready = (rem_q == '0);
  assign pos_o    = pos_q;
  assign dir_up_o = dir_q;

  // fold the code once into range, then take the signed shortest distance
  always_comb begin
    code_x   = {1'b0, in_code};
    code_f   = (code_x >= step_cnt) ? code_x - step_cnt : code_x;
    cnt_s    = $signed({2'b00, step_cnt});
    half_s   = $signed({3'b000, step_cnt[POS_W:1]});
    diff_raw = $signed({2'b00, code_f}) - $signed({3'b000, pos_q});
    if (diff_raw >= half_s)       diff = diff_raw - cnt_s;
    else if (diff_raw < -half_s)  diff = diff_raw + cnt_s;
    else                          diff = diff_raw;
  end

  // one-step hysteresis band between the directions
  always_comb begin
    steps  = '0;
    dir_nx = dir_q;
    if (dir_q) begin
      if (diff > S_ZERO) begin
        steps = POS_W'(diff);
      end else if (diff < S_MONE) begin
        steps  = POS_W'(-diff - S_ONE);
        dir_nx = 1'b0;
      end
    end else begin
      if (diff < S_ZERO) begin
        steps = POS_W'(-diff);
      end else if (diff > S_ONE) begin
        steps  = POS_W'(diff - S_ONE);
        dir_nx = 1'b1;
      end
    end
  end

  always_comb begin
    last_w   = step_cnt - CW'(1);
    pos_last = last_w[POS_W-1:0];
    if (dir_q) pos_step = (pos_q == pos_last) ? '0 : pos_q + POS_W'(1);
    else       pos_step = (pos_q == '0) ? pos_last : pos_q - POS_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q <= '0;
      rem_q <= '0;
      dir_q <= 1'b1;
    end else if (in_valid && in_ready) begin
      rem_q <= steps;
      dir_q <= dir_nx;
    end else if (rem_q != '0) begin
      rem_q <= rem_q - POS_W'(1);
      pos_q <= pos_step;
    end
  end

  // R8: a busy tracker moves every cycle
  a_r8_busy_moves: assert property (@(posedge clk) disable iff (rst)
    !in_ready |=> (pos_q != $past(pos_q)));
  // R8: an idle tracker with nothing offered holds still
  a_r8_idle_holds: assert property (@(posedge clk) disable iff (rst)
    (in_ready && !in_valid) |=> ($stable(pos_q) && in_ready));
  // R7: direction only changes when a code is taken
  a_r7_dir_on_accept: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && in_ready) |=> $stable(dir_q));
  // R9: position stays inside the modulus
  a_r9_pos_range: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, pos_q} < step_cnt));

endmodule

// File: rtl/aqg_quad.sv
module aqg_quad
  import aqg_pkg::*;
#(
  parameter int POS_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [POS_W-1:0] pos,
  input  logic [2:0]       div_log2,
  input  logic [1:0]       phase_sel,
  output logic             quad_a,
  output logic             quad_b
);
  logic [2:0] idx1;
  logic       q0;
  logic       q1;
  logic       g_hi;
  logic       g_lo;
  logic       lead_a;

  always_comb begin
    idx1   = div_log2 + 3'd1;
    q0     = pos[div_log2];
    q1     = pos[idx1];
    g_hi   = q1;
    g_lo   = q1 ^ q0;
    lead_a = (phase_sel == TRI_HI);
    quad_a = lead_a ? g_lo : g_hi;
    quad_b = lead_a ? g_hi : g_lo;
  end

  // R10: the outputs change one at a time under a steady phase select
  a_r10_single_edge: assert property (@(posedge clk) disable iff (rst)
    $stable(phase_sel) |-> !((quad_a != $past(quad_a)) && (quad_b != $past(quad_b))));

endmodule

// File: rtl/angle_quad_gen.sv
module angle_quad_gen #(
  parameter int POS_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pos_valid,
  output logic             pos_ready,
  input  logic [POS_W-1:0] pos_code,
  input  logic [1:0]       res_sel_hi,
  input  logic [1:0]       res_sel_lo,
  input  logic [1:0]       phase_sel,
  output logic             quad_a,
  output logic             quad_b,
  output logic             dir_up
);
  logic [POS_W:0]   step_cnt;
  logic [2:0]       div_log2;
  logic [POS_W-1:0] pos;

  aqg_res_cfg #(.POS_W(POS_W)) cfg_i (
    .clk(clk), .rst(rst), .sel_hi(res_sel_hi), .sel_lo(res_sel_lo),
    .step_cnt(step_cnt), .div_log2(div_log2)
  );

  aqg_tracker #(.POS_W(POS_W)) trk_i (
    .clk(clk), .rst(rst), .in_valid(pos_valid), .in_ready(pos_ready),
    .in_code(pos_code), .step_cnt(step_cnt), .pos_o(pos), .dir_up_o(dir_up)
  );

  aqg_quad #(.POS_W(POS_W)) quad_i (
    .clk(clk), .rst(rst), .pos(pos), .div_log2(div_log2),
    .phase_sel(phase_sel), .quad_a(quad_a), .quad_b(quad_b)
  );

  // R1: reset state at the ports
  a_r1_reset_state: assert property (@(posedge clk)
    $past(rst) |-> (!quad_a && !quad_b && dir_up && pos_ready));

endmodule

// File: tb/angle_quad_gen_tb_top.sv
module angle_quad_gen_tb_top;
  localparam int POS_W = 6;
  localparam logic [1:0] LO = 2'b00, OP = 2'b01, HI = 2'b10, XX = 2'b11;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pos_valid = 1'b0;
  logic pos_ready;
  logic [POS_W-1:0] pos_code = '0;
  logic [1:0] res_sel_hi = HI, res_sel_lo = HI, phase_sel = LO;
  logic quad_a, quad_b, dir_up;

  int n_cmp = 0, n_bad = 0;
  int edge_cnt = 0, dual_cnt = 0;
  logic pa = 1'b0, pb = 1'b0;

  always #10 clk = ~clk;

  angle_quad_gen #(.POS_W(POS_W)) dut_i (
    .clk(clk), .rst(rst), .pos_valid(pos_valid), .pos_ready(pos_ready),
    .pos_code(pos_code), .res_sel_hi(res_sel_hi), .res_sel_lo(res_sel_lo),
    .phase_sel(phase_sel), .quad_a(quad_a), .quad_b(quad_b), .dir_up(dir_up)
  );

  always @(negedge clk) begin
    if (quad_a !== pa) edge_cnt++;
    if (quad_b !== pb) edge_cnt++;
    if (quad_a !== pa && quad_b !== pb) dual_cnt++;
    pa = quad_a;
    pb = quad_b;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ab_of(input int q, input bit a_leads);
    int lo_map[4] = '{0, 1, 3, 2};
    int hi_map[4] = '{0, 2, 3, 1};
    return a_leads ? hi_map[q % 4] : lo_map[q % 4];
  endfunction

  task automatic do_reset(input logic [1:0] h, input logic [1:0] l, input logic [1:0] ph);
    @(negedge clk);
    res_sel_hi = h; res_sel_lo = l; phase_sel = ph; rst = 1'b1; pos_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    edge_cnt = 0;
    dual_cnt = 0;
  endtask

  task automatic send(input int code);
    @(negedge clk);
    while (!pos_ready) @(negedge clk);
    pos_valid = 1'b1;
    pos_code  = POS_W'(code);
    @(negedge clk);
    pos_valid = 1'b0;
    while (!pos_ready) @(negedge clk);
    #1;
  endtask

  task automatic t_reset();
    do_reset(HI, HI, LO);
    chk("R1 quad_a", quad_a, 0);
    chk("R1 quad_b", quad_b, 0);
    chk("R1 dir_up", dir_up, 1);
    chk("R1 pos_ready", pos_ready, 1);
  endtask

  task automatic t_resolution();
    for (int i = 0; i < 10; i++) begin
      logic [1:0] h, l;
      int n, ipf;
      case (i)
        0: begin h = HI; l = HI; n = 64; ipf = 16; end
        1: begin h = HI; l = OP; n = 48; ipf = 12; end
        2: begin h = HI; l = LO; n = 40; ipf = 10; end
        3: begin h = OP; l = HI; n = 64; ipf = 8;  end
        4: begin h = OP; l = OP; n = 40; ipf = 5;  end
        5: begin h = OP; l = LO; n = 64; ipf = 4;  end
        6: begin h = LO; l = HI; n = 48; ipf = 3;  end
        7: begin h = LO; l = OP; n = 64; ipf = 2;  end
        8: begin h = LO; l = LO; n = 64; ipf = 1;  end
        default: begin h = XX; l = XX; n = 40; ipf = 5; end
      endcase
      do_reset(h, l, LO);
      for (int s = 1; s <= n; s++) send(s % n);
      chk($sformatf("R2 edges per cycle sel%0d", i), edge_cnt, 4 * ipf);
      chk($sformatf("R2 ab back at zero sel%0d", i), {quad_a, quad_b}, 0);
    end
  endtask

  task automatic t_cfg_latch();
    do_reset(HI, HI, LO);
    @(negedge clk);
    res_sel_hi = LO; res_sel_lo = LO;
    for (int s = 1; s <= 64; s++) send(s % 64);
    chk("R3 select ignored without reset", edge_cnt, 64);
    do_reset(LO, LO, LO);
    for (int s = 1; s <= 64; s++) send(s % 64);
    chk("R3 select taken at reset", edge_cnt, 4);
  endtask

  task automatic t_phase_low();
    do_reset(LO, LO, LO);
    send(16);
    chk("R4 q1 B leads", {quad_a, quad_b}, ab_of(1, 0));
    send(32);
    chk("R4 q2", {quad_a, quad_b}, ab_of(2, 0));
    send(48);
    chk("R4 q3", {quad_a, quad_b}, ab_of(3, 0));
    chk("R4 edge count", edge_cnt, 3);
  endtask

  task automatic t_phase_hi();
    do_reset(LO, LO, HI);
    send(16);
    chk("R5 q1 A leads", {quad_a, quad_b}, ab_of(1, 1));
    send(48);
    chk("R5 q3", {quad_a, quad_b}, ab_of(3, 1));
    @(negedge clk); phase_sel = OP; #1;
    chk("R4 open phase live", {quad_a, quad_b}, ab_of(3, 0));
    @(negedge clk); phase_sel = XX; #1;
    chk("R4 code 11 phase", {quad_a, quad_b}, ab_of(3, 0));
    @(negedge clk); phase_sel = HI; #1;
    chk("R5 back to high", {quad_a, quad_b}, ab_of(3, 1));
  endtask

  task automatic t_hyst_reverse();
    do_reset(HI, HI, LO);
    send(5);
    chk("R6 start", {quad_a, quad_b}, ab_of(1, 0));
    edge_cnt = 0;
    for (int k = 0; k < 10; k++) send((k % 2 == 0) ? 4 : 5);
    chk("R6 dither edges", edge_cnt, 0);
    chk("R6 dir held", dir_up, 1);
    chk("R6 ab held", {quad_a, quad_b}, ab_of(1, 0));
    edge_cnt = 0;
    send(2);
    chk("R7 reverse dir", dir_up, 0);
    chk("R7 reverse ab pos3", {quad_a, quad_b}, ab_of(3, 0));
    chk("R7 reverse edges", edge_cnt, 2);
    send(4);
    chk("R6 mirror absorb dir", dir_up, 0);
    chk("R6 mirror absorb ab", {quad_a, quad_b}, ab_of(3, 0));
    send(6);
    chk("R7 forward again dir", dir_up, 1);
    chk("R7 forward again ab pos5", {quad_a, quad_b}, ab_of(1, 0));
  endtask

  task automatic t_backpressure();
    int lowc;
    do_reset(HI, HI, LO);
    lowc = 0;
    @(negedge clk);
    pos_valid = 1'b1;
    pos_code  = POS_W'(10);
    @(negedge clk);
    pos_code = POS_W'(30);
    while (!pos_ready) begin
      lowc++;
      if (lowc == 5) pos_valid = 1'b0;
      @(negedge clk);
    end
    pos_valid = 1'b0;
    #1;
    chk("R8 ready low cycles", lowc, 10);
    chk("R8 edges one per step", edge_cnt, 10);
    chk("R8 busy code ignored", {quad_a, quad_b}, ab_of(2, 0));
  endtask

  task automatic t_wrap();
    do_reset(HI, HI, LO);
    send(63);
    chk("R9 one back absorbed", {quad_a, quad_b}, 0);
    send(62);
    chk("R9 down to 63 dir", dir_up, 0);
    chk("R9 down to 63 ab", {quad_a, quad_b}, ab_of(3, 0));
    edge_cnt = 0;
    send(2);
    chk("R9 wrap reverse dir", dir_up, 1);
    chk("R9 wrap reverse ab pos1", {quad_a, quad_b}, ab_of(1, 0));
    chk("R9 wrap reverse edges", edge_cnt, 2);
    do_reset(HI, OP, LO);
    send(46);
    chk("R9 n48 down to 47", {quad_a, quad_b}, ab_of(47, 0));
    edge_cnt = 0;
    send(3);
    chk("R9 n48 wrap up edges", edge_cnt, 3);
    chk("R9 n48 wrap up ab pos2", {quad_a, quad_b}, ab_of(2, 0));
  endtask

  initial begin
    t_reset();
    t_resolution();
    t_cfg_latch();
    t_phase_low();
    t_phase_hi();
    t_hyst_reverse();
    t_backpressure();
    t_wrap();
    do_reset(HI, HI, LO);
    for (int s = 1; s <= 64; s++) send(s % 64);
    chk("R10 no simultaneous edges", dual_cnt, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(20 * 150000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule